// File: doc/BRIEF.md
# USB Status-Stage ACK Gate

This block sits next to the endpoint-zero logic of a USB device controller. It decides which handshake goes back on the status IN stage of a control transfer. It watches the decoded SETUP packets and recognises the two requests that change the device's configuration: SET_CONFIGURATION and SET_INTERFACE. After either one, it takes over the handshake choice for the status IN tokens that follow. In every other case it forwards, unchanged, the choice that the normal endpoint-zero responder makes.

Software controls the gate through one memory-mapped word that holds two write-one-to-set bits:

- **Hold mode.** When this bit is clear, the status stage is acknowledged automatically.
- **Release.** When hold mode is set, every gated status IN token is refused with NAK until software writes the release bit. The first token after that write is acknowledged. The acknowledged token ends the gated status stage and clears the release bit in hardware.

Software can use this window to finish its reconfiguration before the host sees the request complete.

Top module: `usb_status_gate`

## Requirements
- R1: Out of reset, hold mode is 0, release is 0 and no gated status stage is pending. With the default parameters, a read at the register address returns 0x0000007B.
- R2: A setup-valid strobe arms the gate when the request type is 0x00 with request code 9, or when the request type is 0x01 with request code 11. Any other pair, such as 0x80/6 or 0x00/11, does not arm it.
- R3: While the gate is armed and hold mode is 0, a status IN token gets handshake ACK (2'b00), whatever the responder's own choice is. That token ends the gated stage.
- R4: While the gate is armed, hold mode is 1 and release is 0, every status IN token gets NAK (2'b01). The gate stays armed.
- R5: After software writes release, exactly the next status IN token gets ACK. That token ends the gated stage and clears release. Later tokens get the responder's own choice.
- R6: A write sets hold mode when data bit 2 is 1, and sets release when data bit 7 is 1. A write of 0 to either bit changes nothing. A write to any other address changes nothing. Hold mode is cleared only by reset.
- R7: A read at the register address returns hold mode on bit 2 and release on bit 7. The other bits of the low byte read as 1, and bits 31:8 read as 0. Reads at other addresses return 0.
- R8: A bus-reset pulse disarms the gate without changing the register bits.
- R9: While the gate is not armed, the handshake output equals the responder's own choice, using the encoding ACK 2'b00, NAK 2'b01, STALL 2'b10, none 2'b11.
- R10: A setup-valid strobe carrying any request other than the two configuration changes disarms a pending gate. A repeated configuration-change request keeps it armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_reset | input | 1 | USB bus reset seen, one-cycle pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (12) | Register address for read and write |
| reg_wdata | input | DATA_W (32) | Write data |
| reg_rdata | output | DATA_W (32) | Read data, combinational from reg_addr |
| setup_valid | input | 1 | Decoded SETUP packet strobe |
| setup_req_type | input | 8 | Request-type byte of the SETUP packet |
| setup_request | input | 8 | Request-code byte of the SETUP packet |
| status_in_tok | input | 1 | Status IN token on endpoint zero this cycle |
| resp_dflt | input | 2 | Handshake chosen by the normal responder |
| resp_hs | output | 2 | Handshake to send |

## Verification
The assertions check every cycle that an armed, unreleased hold yields NAK, that automatic mode yields ACK, and that a disarmed gate passes the responder's choice through. They also check that the pending flag reacts correctly to arm strobes, disarm strobes, bus reset and an acknowledged token, and that hold mode never drops once it is set. The bench scenarios are the only place where the end-to-end sequences show up: several NAKs in a row, then exactly one ACK after the release write followed by a return to the responder's choice. The scenarios also cover the read-back layout with its must-be-one bits, and the request pairs that look close to a configuration change but do not arm the gate.

// File: rtl/usb_stsgate_pkg.sv
package usb_stsgate_pkg;

  typedef enum logic [1:0] {
    HS_ACK   = 2'b00,
    HS_NAK   = 2'b01,
    HS_STALL = 2'b10,
    HS_NONE  = 2'b11
  } hs_e;

  localparam logic [7:0] RT_TO_DEVICE = 8'h00;
  localparam logic [7:0] RT_TO_IFACE  = 8'h01;
  localparam logic [7:0] RQ_SET_CFG   = 8'd9;
  localparam logic [7:0] RQ_SET_IFACE = 8'd11;

  // True for the two requests whose status stage may be held back.
  function automatic logic is_cfg_change(input logic [7:0] rtype, input logic [7:0] rcode);
    return ((rtype == RT_TO_DEVICE) && (rcode == RQ_SET_CFG)) ||
           ((rtype == RT_TO_IFACE)  && (rcode == RQ_SET_IFACE));
  endfunction

  // Gate grants the status stage when armed and either automatic or released.
  function automatic logic gate_grants(input logic armed, input logic hold, input logic rel);
    return armed && (!hold || rel);
  endfunction

  // Handshake choice: gate overrides only while armed.
  function automatic logic [1:0] pick_hs(input logic armed, input logic hold,
                                         input logic rel, input logic [1:0] dflt);
    if (!armed)                        return dflt;
    else if (gate_grants(armed, hold, rel)) return HS_ACK;
    else                               return HS_NAK;
  endfunction

endpackage

// File: rtl/stsgate_regs.sv
module stsgate_regs #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h008,
  parameter int MODE_BIT = 2,
  parameter int REL_BIT  = 7,
  parameter logic MODE_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              consume,
  output logic              hold_q,
  output logic              rel_q,
  output logic [DATA_W-1:0] rdata
);

  localparam logic [DATA_W-1:0] LOW_LANE  = DATA_W'(8'hFF);
  localparam logic [DATA_W-1:0] CTRL_MASK = (DATA_W'(1) << MODE_BIT) | (DATA_W'(1) << REL_BIT);
  localparam logic [DATA_W-1:0] MB1_MASK  = LOW_LANE & ~CTRL_MASK;

  logic addr_hit, wr_hit, set_hold, set_rel;
  logic unused_wbits;

  assign addr_hit = (addr == REG_ADDR);
  assign wr_hit   = we && addr_hit;
  assign set_hold = wr_hit && wdata[MODE_BIT];
  assign set_rel  = wr_hit && wdata[REL_BIT];
  assign unused_wbits = ^wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= MODE_RST;
      rel_q  <= 1'b0;
    end else begin
      if (set_hold) hold_q <= 1'b1;
      if (set_rel)       rel_q <= 1'b1;
      else if (consume)  rel_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr_hit)
      rdata = MB1_MASK | (DATA_W'(hold_q) << MODE_BIT) | (DATA_W'(rel_q) << REL_BIT);
  end

  // R6
  hold_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_q |=> hold_q);

  // R5
  rel_consumed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !set_rel) |=> !rel_q);

  // R6
  zero_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !set_hold && !set_rel && !consume) |=> ($stable(hold_q) && $stable(rel_q)));

endmodule

// File: rtl/stsgate_setup_dec.sv
module stsgate_setup_dec
  import usb_stsgate_pkg::*;
(
  input  logic       setup_valid,
  input  logic [7:0] rtype,
  input  logic [7:0] rcode,
  output logic       arm,
  output logic       disarm
);

  logic match;
  assign match  = is_cfg_change(rtype, rcode);
  assign arm    = setup_valid && match;
  assign disarm = setup_valid && !match;

endmodule

// File: rtl/stsgate_pend.sv
module stsgate_pend (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_reset,
  input  logic arm,
  input  logic disarm,
  input  logic tok,
  input  logic grant,
  output logic pending,
  output logic consume
);

  assign consume = tok && pending && grant;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          pending <= 1'b0;
    else if (bus_reset)  pending <= 1'b0;
    else if (arm)        pending <= 1'b1;
    else if (disarm)     pending <= 1'b0;
    else if (consume)    pending <= 1'b0;
  end

  // R8
  bus_reset_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_reset |=> !pending);

  // R2
  arm_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && !bus_reset) |=> pending);

  // R10
  other_setup_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (disarm && !bus_reset) |=> !pending);

  // R5
  ack_ends_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (consume && !arm) |=> !pending);

endmodule

// File: rtl/usb_status_gate.sv
module usb_status_gate
  import usb_stsgate_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter logic [ADDR_W-1:0] REG_ADDR = 12'h008,
  parameter int MODE_BIT = 2,
  parameter int REL_BIT  = 7,
  parameter logic MODE_RST = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_reset,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              setup_valid,
  input  logic [7:0]        setup_req_type,
  input  logic [7:0]        setup_request,
  input  logic              status_in_tok,
  input  logic [1:0]        resp_dflt,
  output logic [1:0]        resp_hs
);

  logic hold_q, rel_q, arm, disarm, pending, consume, grant;

  stsgate_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR),
    .MODE_BIT(MODE_BIT), .REL_BIT(REL_BIT), .MODE_RST(MODE_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .consume(consume), .hold_q(hold_q), .rel_q(rel_q), .rdata(reg_rdata)
  );

  stsgate_setup_dec u_dec (
    .setup_valid(setup_valid), .rtype(setup_req_type), .rcode(setup_request),
    .arm(arm), .disarm(disarm)
  );

  assign grant = gate_grants(pending, hold_q, rel_q);

  stsgate_pend u_pend (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .arm(arm), .disarm(disarm),
    .tok(status_in_tok), .grant(grant), .pending(pending), .consume(consume)
  );

  assign resp_hs = pick_hs(pending, hold_q, rel_q, resp_dflt);

  // R4
  held_nak_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_in_tok && pending && hold_q && !rel_q) |-> (resp_hs == HS_NAK));

  // R3
  auto_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !hold_q) |-> (resp_hs == HS_ACK));

  // R9
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pending |-> (resp_hs == resp_dflt));

  // R4
  nak_keeps_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_in_tok && pending && !grant && !bus_reset && !disarm) |=> pending);

endmodule

// File: tb/usb_status_gate_test.sv
`timescale 1ns/100ps
module usb_status_gate_test;

  localparam logic [1:0] ACK = 2'b00, NAK = 2'b01, STALL = 2'b10, NONE = 2'b11;
  localparam logic [11:0] RA = 12'h008;

  logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0, reg_we = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;
  logic setup_valid = 1'b0, status_in_tok = 1'b0;
  logic [7:0] setup_req_type = '0, setup_request = '0;
  logic [1:0] resp_dflt = STALL, resp_hs;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [1:0] exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  usb_status_gate uut (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .setup_valid(setup_valid), .setup_req_type(setup_req_type),
    .setup_request(setup_request), .status_in_tok(status_in_tok),
    .resp_dflt(resp_dflt), .resp_hs(resp_hs)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Driver: one status IN token, expected handshake pushed to the scoreboard.
  task automatic tok(input logic [1:0] exp, input string tag);
    @(negedge clk);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    status_in_tok = 1'b1;
    @(negedge clk);
    status_in_tok = 1'b0;
  endtask

  // Monitor: compares the handshake during each token cycle.
  initial forever begin
    @(negedge clk);
    #1;
    if (status_in_tok) begin
      if (exp_q.size() == 0) check("monitor: token without expectation", 32'(resp_hs), 32'hx);
      else check(tag_q.pop_front(), 32'(resp_hs), 32'(exp_q.pop_front()));
    end
  end

  task automatic setup(input logic [7:0] rt, input logic [7:0] rq);
    @(negedge clk);
    setup_valid = 1'b1; setup_req_type = rt; setup_request = rq;
    @(negedge clk);
    setup_valid = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = RA;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1;
    check(tag, reg_rdata, exp);
    reg_addr = RA;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(RA, 32'h7B, "R1 R7 reset read");
    #1 check("R1 R9 reset passthrough", 32'(resp_hs), 32'(STALL));
    rd(12'h00C, 32'h0, "R7 other address reads 0");

    // automatic mode
    setup(8'h00, 8'd9);
    tok(ACK, "R2 R3 set-config auto ack");
    tok(STALL, "R3 R9 stage ended, passthrough");
    setup(8'h01, 8'd11);
    resp_dflt = NAK;
    tok(ACK, "R2 R3 set-interface auto ack over NAK");
    resp_dflt = STALL;
    setup(8'h80, 8'd6);
    tok(STALL, "R2 get-descriptor not gated");
    setup(8'h00, 8'd11);
    tok(STALL, "R2 wrong type not gated");

    // register writes
    wr(RA, 32'h0);
    rd(RA, 32'h7B, "R6 zero write no effect");
    wr(12'h010, 32'hFF);
    rd(RA, 32'h7B, "R6 wrong address write ignored");
    wr(RA, 32'h7F);
    rd(RA, 32'h7F, "R6 R7 hold mode set");
    wr(RA, 32'h7B);
    rd(RA, 32'h7F, "R6 hold not cleared by zero");

    // held mode
    setup(8'h00, 8'd9);
    for (int i = 0; i < 4; i++) tok(NAK, "R4 held nak");
    wr(RA, 32'hFF);
    rd(RA, 32'hFF, "R7 release readback");
    tok(ACK, "R5 first token after release");
    rd(RA, 32'h7F, "R5 release cleared by ack");
    tok(STALL, "R5 only one ack");
    tok(STALL, "R5 still passthrough");

    // bus reset
    setup(8'h01, 8'd11);
    tok(NAK, "R4 armed before bus reset");
    @(negedge clk); bus_reset = 1'b1;
    @(negedge clk); bus_reset = 1'b0;
    tok(STALL, "R8 bus reset disarms");
    rd(RA, 32'h7F, "R8 register kept over bus reset");

    // new setup
    setup(8'h00, 8'd9);
    tok(NAK, "R10 armed");
    setup(8'h80, 8'd0);
    tok(STALL, "R10 other setup disarms");
    setup(8'h00, 8'd9);
    setup(8'h01, 8'd11);
    tok(NAK, "R10 repeated config request stays armed");
    wr(RA, 32'hFF);
    tok(ACK, "R5 release after re-arm");

    // passthrough of each code
    resp_dflt = ACK;  tok(ACK, "R9 pass ack");
    resp_dflt = NAK;  tok(NAK, "R9 pass nak");
    resp_dflt = NONE; tok(NONE, "R9 pass none");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) check("scoreboard drained", 32'(exp_q.size()), 32'h0);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule